// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block steps an on-chip debug unit through a short chain of trigger states. The chain runs from State1 through State2 and State3 to a Final state. Three comparator channels feed it single-cycle match pulses. Each pulse counts only while that comparator's enable bit is high. Each non-final state has its own 4-bit route code. The code picks an entry from a fixed menu that says which channel leads to which next state.

Software writes the three route codes while the unit is disarmed. Raising the arm input starts the chain from State1. When Final is reached, the block gives a one-cycle trigger pulse and stays in Final until the unit is disarmed. When several matches land in the same cycle, a route to Final wins. If none of them goes to Final, the lowest-numbered channel wins.

Top module: `dbg_trig_seq`

## Requirements
- R1: A match pulse on channel k has an effect only when `cmp_en[k]` is 1 in the same cycle. Otherwise it is discarded.
- R2: The route codes map channels (m0 = bit 0 of `match_in`) to next states as follows:
  - 1: m0 goes to State2.
  - 2: m1 goes to State2.
  - 3: m2 goes to State2.
  - 4: m0 goes to State3.
  - 5: m1 goes to State3.
  - 6: m2 goes to State3.
  - 7: m0 or m1 goes to State2.
  - 8: m0 goes to State2 and m1 goes to State3.
  - 9: m0 goes to State2 and m2 goes to State3.
  - 10: any channel goes to Final.
  - 11: m0 or m2 goes to Final, and m1 goes to State2.
  - 12: m0 goes to Final and m1 goes to State3.
- R3: Codes 0, 13, 14 and 15 are reserved and cause no transition. A match on a channel that the active code does not name leaves the state unchanged.
- R4: With simultaneous matches, a channel routed to Final wins. Otherwise the lowest-numbered matching channel picks the next state.
- R5: `wr_sel` picks the field to load: 0 selects the State1 code, 1 the State2 code and 2 the State3 code. A value of 3 writes nothing. The code of the current state is the one applied.
- R6: A write with `wr_en` high takes effect only while `arm` is 0. Writes made while armed are ignored.
- R7: `state_o` encodes the state as 0 = State1, 1 = State2, 2 = State3 and 3 = Final. While `arm` is 0 the state is State1 and matches are ignored, so arming always starts from State1.
- R8: Once Final is reached, it holds for as long as `arm` stays 1, whatever matches arrive.
- R9: `trig_o` is 1 for exactly the one cycle in which `state_o` first shows Final.
- R10: A synchronous active-high `rst` clears all three codes to 0, sets State1 and clears `trig_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Unit armed when 1 |
| cmp_en | input | 3 | Per-channel comparator enable |
| match_in | input | 3 | Per-channel one-cycle match pulse |
| wr_en | input | 1 | Route-code write strobe |
| wr_sel | input | 2 | Target field of the write |
| wr_data | input | 4 | Route code to write |
| state_o | output | 2 | Current sequencer state |
| trig_o | output | 1 | One-cycle pulse on entry to Final |

## Verification
A vector table loads each menu code into the State1 field and fires single matches, pairs and all three channels at once. This tells the lowest-channel rule apart from the Final-first rule, and named channels apart from unnamed ones. Some vectors clear enable bits under a match, to separate gating from routing. Further vectors use reserved codes, to separate them from valid ones. Directed runs walk the chain through all three fields to Final. They then check that the trigger lasts exactly one cycle, that Final ignores later matches, and that an armed write leaves routing unchanged. They also check that disarming returns the chain to State1.

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq #(
  parameter int NCH = 3,
  parameter int CW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           arm,
  input  logic [NCH-1:0] cmp_en,
  input  logic [NCH-1:0] match_in,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [CW-1:0]  wr_data,
  output logic [1:0]     state_o,
  output logic           trig_o
);
  localparam logic [1:0] ST1 = 2'd0, ST2 = 2'd1, ST3 = 2'd2, FIN = 2'd3;
  localparam logic [2:0] NO = 3'b000, G2 = {1'b1, ST2}, G3 = {1'b1, ST3}, GF = {1'b1, FIN};
  localparam int RW = 3 * NCH;

  logic [CW-1:0] code_q [4];
  logic [1:0]    state_q, nxt;
  logic          trig_q;
  logic [NCH-1:0] hit;
  logic [RW-1:0]  rt;

  assign hit = match_in & cmp_en;

  function automatic logic [8:0] menu(input logic [3:0] c);
    case (c)
      4'd1:  menu = {NO, NO, G2};
      4'd2:  menu = {NO, G2, NO};
      4'd3:  menu = {G2, NO, NO};
      4'd4:  menu = {NO, NO, G3};
      4'd5:  menu = {NO, G3, NO};
      4'd6:  menu = {G3, NO, NO};
      4'd7:  menu = {NO, G2, G2};
      4'd8:  menu = {NO, G3, G2};
      4'd9:  menu = {G3, NO, G2};
      4'd10: menu = {GF, GF, GF};
      4'd11: menu = {GF, G2, GF};
      4'd12: menu = {NO, G3, GF};
      default: menu = 9'd0;
    endcase
  endfunction

  assign rt = menu(code_q[state_q]);

  always_comb begin
    logic          fin_hit, low_ok;
    logic [1:0]    low_tgt;
    fin_hit = 1'b0;
    low_ok  = 1'b0;
    low_tgt = ST1;
    for (int ch = NCH - 1; ch >= 0; ch--) begin
      if (hit[ch] && rt[3*ch+2]) begin
        low_ok  = 1'b1;
        low_tgt = rt[3*ch +: 2];
        if (rt[3*ch +: 2] == FIN) fin_hit = 1'b1;
      end
    end
    if (!arm)              nxt = ST1;
    else if (state_q == FIN) nxt = FIN;
    else if (fin_hit)      nxt = FIN;
    else if (low_ok)       nxt = low_tgt;
    else                   nxt = state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) code_q[i] <= '0;
      state_q <= ST1;
      trig_q  <= 1'b0;
    end else begin
      if (wr_en && !arm && wr_sel != 2'd3) code_q[wr_sel] <= wr_data;
      state_q <= nxt;
      trig_q  <= (nxt == FIN) && (state_q != FIN);
    end
  end

  assign state_o = state_q;
  assign trig_o  = trig_q;

  assert_trig_in_final_R9: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> state_o == FIN);
  assert_trig_single_R9: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o);
  assert_disarm_home_R7: assert property (@(posedge clk) disable iff (rst)
    !arm |=> state_o == ST1);
  assert_final_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (arm && state_o == FIN) |=> state_o == FIN);
  assert_gated_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (arm && (match_in & cmp_en) == '0) |=> $stable(state_o));
  assert_armed_lock_R6: assert property (@(posedge clk) disable iff (rst)
    arm |=> ($stable(code_q[0]) && $stable(code_q[1]) && $stable(code_q[2])));
endmodule

// File: tb/dbg_trig_seq_tb.sv
module dbg_trig_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1, arm = 1'b0, wr_en = 1'b0;
  logic [2:0] cmp_en = 3'b111, match_in = 3'b000;
  logic [1:0] wr_sel = 2'd0;
  logic [3:0] wr_data = 4'd0;
  logic [1:0] state_o;
  logic trig_o;
  int nvec = 0, nbad = 0;

  always #2.5 clk = ~clk;

  dbg_trig_seq dut_i (.clk(clk), .rst(rst), .arm(arm), .cmp_en(cmp_en), .match_in(match_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .state_o(state_o), .trig_o(trig_o));

  // {code, enables, matches, expected state}
  localparam logic [11:0] VEC [18] = '{
    {4'd1,  3'b111, 3'b001, 2'd1},  // R2
    {4'd2,  3'b111, 3'b010, 2'd1},  // R2
    {4'd3,  3'b111, 3'b100, 2'd1},  // R2
    {4'd4,  3'b111, 3'b001, 2'd2},  // R2
    {4'd5,  3'b111, 3'b010, 2'd2},  // R2
    {4'd6,  3'b111, 3'b100, 2'd2},  // R2
    {4'd7,  3'b111, 3'b010, 2'd1},  // R2
    {4'd8,  3'b111, 3'b011, 2'd1},  // R4 lowest channel
    {4'd9,  3'b111, 3'b100, 2'd2},  // R2
    {4'd10, 3'b111, 3'b100, 2'd3},  // R2
    {4'd11, 3'b111, 3'b011, 2'd3},  // R4 final first
    {4'd12, 3'b111, 3'b011, 2'd3},  // R4 final first
    {4'd12, 3'b111, 3'b010, 2'd2},  // R2
    {4'd1,  3'b111, 3'b010, 2'd0},  // R3 unnamed
    {4'd0,  3'b111, 3'b111, 2'd0},  // R3 reserved
    {4'd14, 3'b111, 3'b111, 2'd0},  // R3 reserved
    {4'd4,  3'b110, 3'b001, 2'd0},  // R1 gated
    {4'd9,  3'b011, 3'b101, 2'd1}   // R1 gated ch2
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] st, input logic tg);
    nvec++;
    if (state_o !== st || trig_o !== tg) begin
      nbad++;
      $display("FAIL %s: state=%0d trig=%0b expected state=%0d trig=%0b", req, state_o, trig_o, st, tg);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] m);
    match_in = m; tick(); match_in = 3'b000;
  endtask

  initial begin
    #1000000;
    nbad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    chk("R10 reset", 2'd0, 1'b0);
    arm = 1'b1; tick();
    pulse(3'b111);
    chk("R10 codes cleared", 2'd0, 1'b0);
    arm = 1'b0; tick();

    foreach (VEC[i]) begin
      arm = 1'b0; tick();
      wr(2'd0, VEC[i][11:8]);
      cmp_en = VEC[i][7:5];
      arm = 1'b1; tick();
      pulse(VEC[i][4:2]);
      chk($sformatf("R2/R3/R4/R1 vector %0d", i), VEC[i][1:0], VEC[i][1:0] == 2'd3);
    end

    arm = 1'b0; cmp_en = 3'b111; tick();
    wr(2'd0, 4'd1); wr(2'd1, 4'd5); wr(2'd2, 4'd10); wr(2'd3, 4'd0);
    arm = 1'b1; tick();
    chk("R7 arm starts State1", 2'd0, 1'b0);
    pulse(3'b001); chk("R5 State1 code", 2'd1, 1'b0);
    pulse(3'b001); chk("R5 State2 code ignores m0", 2'd1, 1'b0);
    pulse(3'b010); chk("R5 State2 code", 2'd2, 1'b0);
    pulse(3'b100); chk("R9 trigger on Final", 2'd3, 1'b1);
    tick();        chk("R9 trigger one cycle", 2'd3, 1'b0);
    pulse(3'b111); chk("R8 Final sticky", 2'd3, 1'b0);
    arm = 1'b0; tick();
    chk("R7 disarm to State1", 2'd0, 1'b0);
    pulse(3'b001); chk("R7 disarmed ignores match", 2'd0, 1'b0);

    arm = 1'b1; tick();
    wr(2'd0, 4'd3);
    pulse(3'b100); chk("R6 armed write ignored", 2'd0, 1'b0);
    pulse(3'b001); chk("R6 old code kept", 2'd1, 1'b0);
    pulse(3'b010); chk("R5 wr_sel 3 harmless", 2'd2, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule